// File: doc/BRIEF.md
# Fused-Operation 64-bit Integer ALU

This block is a purely combinational integer ALU for a 64-bit datapath. It takes two 64-bit source operands and a 7-bit operation code. In the same cycle it returns a 64-bit result and a flag that says whether a branch is taken. It covers the usual arithmetic, compare, shift, rotate and logic operations. It also covers single-bit manipulation, 32-bit word forms that sign-extend their result, shift-and-add, right-shift-and-add, and fused forms that join an add or a logic operation to a truncation or an extension.

The three upper bits of the code select an operation class, and the lower four bits select the operation within that class. A branch code leaves the result at zero and drives only the taken flag. The block has no clock, no state and no handshake. The surrounding issue logic holds the operands stable for as long as it needs the outputs, and the outputs settle after one combinational pass.

Top module: `fuse_alu`

## Requirements
- R1: The class field is op[6:4]. Any code not listed in R2 to R12 gives a result of 0. Outside class 111 the taken flag is always 0.
- R2: Code 0100001 gives src1+src2. Code 0110000 gives src1-src2. Code 0100000 gives the zero-extended src1[31:0] plus src2. Code 0100010 gives src2 plus src1[0]. All wrap modulo 2^64.
- R3: Codes 0101001, 0101011, 0101101 and 0101111 give (src1 << n) + src2 for n = 1, 2, 3 and 4. Codes 0101000, 0101010 and 0101100 do the same for n = 1, 2 and 3, but first zero-extend src1[31:0].
- R4: Codes 0100100, 0100101, 0100110 and 0100111 give (src1 >> k) + src2, a logical right shift with k = 29, 30, 31 and 32.
- R5: Code 0110001 gives 1 if src1 < src2 unsigned, else 0. Code 0110010 is the same compare, but signed. Codes 0110100, 0110101, 0110110 and 0110111 give unsigned max, unsigned min, signed max and signed min.
- R6: The shift amount is src2[5:0]. Code 0000001 is a left shift and 0000101 a logical right shift. Code 0000111 is an arithmetic right shift. Codes 0001001 and 0001011 rotate left and right. Code 0000000 shifts the zero-extended src1[31:0] left. A rotate by 0 returns src1.
- R7: The bit index is src2[5:0]. Code 0000010 clears that bit of src1, 0000011 sets it and 0000100 toggles it. Code 0000110 returns the bit in position 0, with all other bits 0.
- R8: The word forms take the low 32 bits of the 32-bit result and sign-extend it to 64 bits. The codes are: add 0010000, src1[0]+src2 0010001, sub 0010010, left shift 0011000, logical right shift 0011001, arithmetic right shift 0011010, rotate left 0011100 and rotate right 0011101. These codes operate on src1[31:0] with amount src2[4:0].
- R9: Four fused add codes each keep only part of src1+src2. Code 0010100 keeps bit 0. Code 0010101 keeps bits [7:0], zero-extended. Code 0010110 zero-extends bits [15:0]. Code 0010111 sign-extends bits [15:0].
- R10: Class 100 uses op[2:1] to select the base: 00 AND, 01 OR, 10 XOR, 11 or-combine. The or-combine base sets each byte of src1 to FF if it is nonzero and to 00 otherwise. For the first three bases, op[0]=1 inverts src2 first. Code 1000111 is unused.
- R11: The other class 100 and class 101 codes are: 1001000 sign-extends byte 0 and 1001010 sign-extends halfword 0. Code 1001001 gives {src2[7:0],src1[7:0]} zero-extended. Code 1001011 gives {src2[15:0],src1[15:0]} sign-extended. Code 1010000 reverses the bits within each byte. Code 1010001 reverses the byte order. Code 1010010 gives {src2[31:0],src1[31:0]}.
- R12: A class 110 code {110,m,z} applies the class 100 base m to src1 and src2 with no inversion. It returns only bit 0 when z=0, and the zero-extended low 16 bits when z=1. The eight codes 1100000 to 1100111 are all valid.
- R13: A class 111 code with op[0]=0 is a branch, and its result is 0. Bits op[3:2] give the condition: 00 equal, 10 signed less-than, 11 unsigned less-than. Setting op[1] inverts the condition. op[3:2]=01 or op[0]=1 never takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 7 | Operation code: class in [6:4], function in [3:0] |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand; also the shift amount or bit index |
| result_o | output | 64 | Operation result, 0 for branches and unused codes |
| taken_o | output | 1 | Branch condition met |

## Verification
The hardest cases to reach from the ports are where the amount masking and the sign boundaries matter. Examples are a src2 with bits set above the six index bits, a rotate by zero, a word result whose bit 31 decides the upper half, and signed compares across the 0x8000... boundary. The operand grid is built from values made to hit these: 63, 32, 0x45, 0xFFFFFFFF and both sign extremes. Every pair from this grid runs through all 128 codes. A pseudo-random set of operand pairs then adds broader coverage of the carry chains.

// File: rtl/fuse_alu_pkg.sv
package fuse_alu_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int HSHW = $clog2(HALF);
  localparam int OPW  = 7;
  localparam int FNW  = 4;
  localparam int BYTE = 8;
  localparam int HW16 = 16;
  localparam int NBYTES = XLEN / BYTE;

  typedef logic [XLEN-1:0] xword_t;
  typedef logic [HALF-1:0] hword_t;

  typedef enum logic [2:0] {
    CL_SHIFT  = 3'b000,
    CL_WORD   = 3'b001,
    CL_ADD    = 3'b010,
    CL_SUB    = 3'b011,
    CL_MISC0  = 3'b100,
    CL_MISC1  = 3'b101,
    CL_FUSE   = 3'b110,
    CL_BRANCH = 3'b111
  } op_class_e;

  function automatic xword_t sext_half(input hword_t v);
    return {{HALF{v[HALF-1]}}, v};
  endfunction

  function automatic xword_t zext_half(input hword_t v);
    return {{HALF{1'b0}}, v};
  endfunction

  function automatic xword_t or_combine(input xword_t v);
    xword_t r;
    for (int i = 0; i < NBYTES; i++) r[i*BYTE +: BYTE] = {BYTE{|v[i*BYTE +: BYTE]}};
    return r;
  endfunction

  function automatic xword_t bit_rev_bytes(input xword_t v);
    xword_t r;
    for (int i = 0; i < NBYTES; i++)
      for (int j = 0; j < BYTE; j++) r[i*BYTE + j] = v[i*BYTE + BYTE-1-j];
    return r;
  endfunction

  function automatic xword_t byte_swap(input xword_t v);
    xword_t r;
    for (int i = 0; i < NBYTES; i++) r[i*BYTE +: BYTE] = v[(NBYTES-1-i)*BYTE +: BYTE];
    return r;
  endfunction
endpackage

// File: rtl/fuse_alu_shift.sv
module fuse_alu_shift
  import fuse_alu_pkg::*;
(
  input  op_class_e        cls_i,
  input  logic [FNW-1:0]   fn_i,
  input  xword_t           src1_i,
  input  logic [SHW-1:0]   amt_i,
  output xword_t           res_o,
  output logic             hit_o
);
  localparam logic [SHW:0] FULL = (SHW+1)'(XLEN);

  xword_t              onehot;
  xword_t              rot_l;
  xword_t              rot_r;
  logic [SHW:0]        back;
  logic signed [XLEN-1:0] s1;

  always_comb begin
    onehot = xword_t'(1) << amt_i;
    back   = FULL - {1'b0, amt_i};
    rot_l  = (src1_i << amt_i) | (src1_i >> back);
    rot_r  = (src1_i >> amt_i) | (src1_i << back);
    s1     = src1_i;
    res_o  = '0;
    hit_o  = (cls_i == CL_SHIFT);
    case (fn_i)
      4'h0: res_o = zext_half(src1_i[HALF-1:0]) << amt_i;
      4'h1: res_o = src1_i << amt_i;
      4'h2: res_o = src1_i & ~onehot;
      4'h3: res_o = src1_i | onehot;
      4'h4: res_o = src1_i ^ onehot;
      4'h5: res_o = src1_i >> amt_i;
      4'h6: res_o[0] = src1_i[amt_i];
      4'h7: res_o = xword_t'(s1 >>> amt_i);
      4'h9: res_o = rot_l;
      4'hB: res_o = rot_r;
      default: hit_o = 1'b0;
    endcase
    if (!hit_o) res_o = '0;
  end

  always_comb begin
    // R6
    rot_zero_amt_chk: assert (!(hit_o && (fn_i == 4'h9 || fn_i == 4'hB) && amt_i == '0)
                              || res_o == src1_i);
  end
endmodule

// File: rtl/fuse_alu_arith.sv
module fuse_alu_arith
  import fuse_alu_pkg::*;
#(
  parameter int SR_BASE = 29,
  parameter int N_SHADD = 4
)(
  input  op_class_e      cls_i,
  input  logic [FNW-1:0] fn_i,
  input  xword_t         src1_i,
  input  xword_t         src2_i,
  output xword_t         res_o,
  output logic           hit_o
);
  localparam logic [HSHW:0] HFULL = (HSHW+1)'(HALF);

  hword_t lo1;
  xword_t uw1;
  xword_t sum, diff, odd_sum;
  logic [HSHW-1:0] wamt;
  logic [HSHW:0]   wback;
  hword_t w_sll, w_srl, w_sra, w_rol, w_ror;
  logic signed [HALF-1:0] lo1s;
  xword_t sr_add    [4];
  xword_t sh_add    [N_SHADD];
  xword_t sh_add_uw [N_SHADD-1];

  assign lo1     = src1_i[HALF-1:0];
  assign uw1     = zext_half(lo1);
  assign sum     = src1_i + src2_i;
  assign diff    = src1_i - src2_i;
  assign odd_sum = src2_i + xword_t'(src1_i[0]);

  for (genvar k = 0; k < 4; k++) begin : g_sradd
    assign sr_add[k] = (src1_i >> (SR_BASE + k)) + src2_i;
  end
  for (genvar k = 0; k < N_SHADD; k++) begin : g_shadd
    assign sh_add[k] = (src1_i << (k + 1)) + src2_i;
  end
  for (genvar k = 0; k < N_SHADD-1; k++) begin : g_shadd_uw
    assign sh_add_uw[k] = (uw1 << (k + 1)) + src2_i;
  end

  always_comb begin
    wamt  = src2_i[HSHW-1:0];
    wback = HFULL - {1'b0, wamt};
    lo1s  = lo1;
    w_sll = lo1 << wamt;
    w_srl = lo1 >> wamt;
    w_sra = hword_t'(lo1s >>> wamt);
    w_rol = (lo1 << wamt) | (lo1 >> wback);
    w_ror = (lo1 >> wamt) | (lo1 << wback);
  end

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    case (cls_i)
      CL_WORD: begin
        case (fn_i)
          4'h0: res_o = sext_half(sum[HALF-1:0]);
          4'h1: res_o = sext_half(odd_sum[HALF-1:0]);
          4'h2: res_o = sext_half(diff[HALF-1:0]);
          4'h4: res_o = xword_t'(sum[0]);
          4'h5: res_o = xword_t'(sum[BYTE-1:0]);
          4'h6: res_o = xword_t'(sum[HW16-1:0]);
          4'h7: res_o = {{(XLEN-HW16){sum[HW16-1]}}, sum[HW16-1:0]};
          4'h8: res_o = sext_half(w_sll);
          4'h9: res_o = sext_half(w_srl);
          4'hA: res_o = sext_half(w_sra);
          4'hC: res_o = sext_half(w_rol);
          4'hD: res_o = sext_half(w_ror);
          default: hit_o = 1'b0;
        endcase
      end
      CL_ADD: begin
        case (fn_i)
          4'h0: res_o = uw1 + src2_i;
          4'h1: res_o = sum;
          4'h2: res_o = odd_sum;
          4'h4, 4'h5, 4'h6, 4'h7: res_o = sr_add[fn_i[1:0]];
          4'h8: res_o = sh_add_uw[0];
          4'h9: res_o = sh_add[0];
          4'hA: res_o = sh_add_uw[1];
          4'hB: res_o = sh_add[1];
          4'hC: res_o = sh_add_uw[2];
          4'hD: res_o = sh_add[2];
          4'hF: res_o = sh_add[3];
          default: hit_o = 1'b0;
        endcase
      end
      CL_SUB: begin
        case (fn_i)
          4'h0: res_o = diff;
          4'h1: res_o = xword_t'(src1_i < src2_i);
          4'h2: res_o = xword_t'($signed(src1_i) < $signed(src2_i));
          4'h4: res_o = (src1_i > src2_i) ? src1_i : src2_i;
          4'h5: res_o = (src1_i < src2_i) ? src1_i : src2_i;
          4'h6: res_o = ($signed(src1_i) > $signed(src2_i)) ? src1_i : src2_i;
          4'h7: res_o = ($signed(src1_i) < $signed(src2_i)) ? src1_i : src2_i;
          default: hit_o = 1'b0;
        endcase
      end
      default: hit_o = 1'b0;
    endcase
    if (!hit_o) res_o = '0;
  end

  always_comb begin
    // R2
    sub_inverse_chk: assert (!(cls_i == CL_SUB && fn_i == 4'h0) || (res_o + src2_i) == src1_i);
  end
endmodule

// File: rtl/fuse_alu_logic.sv
module fuse_alu_logic
  import fuse_alu_pkg::*;
(
  input  op_class_e      cls_i,
  input  logic [FNW-1:0] fn_i,
  input  xword_t         src1_i,
  input  xword_t         src2_i,
  output xword_t         res_o,
  output logic           hit_o
);
  xword_t rhs;
  xword_t base;

  always_comb begin
    rhs = (cls_i == CL_MISC0 && fn_i[0]) ? ~src2_i : src2_i;
    case (fn_i[2:1])
      2'b00:   base = src1_i & rhs;
      2'b01:   base = src1_i | rhs;
      2'b10:   base = src1_i ^ rhs;
      default: base = or_combine(src1_i);
    endcase
  end

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    case (cls_i)
      CL_MISC0: begin
        if (!fn_i[3]) begin
          if (fn_i[2:1] == 2'b11 && fn_i[0]) hit_o = 1'b0;
          else res_o = base;
        end else if (!fn_i[2]) begin
          case (fn_i[1:0])
            2'b00: res_o = {{(XLEN-BYTE){src1_i[BYTE-1]}}, src1_i[BYTE-1:0]};
            2'b01: res_o = xword_t'({src2_i[BYTE-1:0], src1_i[BYTE-1:0]});
            2'b10: res_o = {{(XLEN-HW16){src1_i[HW16-1]}}, src1_i[HW16-1:0]};
            default: res_o = sext_half({src2_i[HW16-1:0], src1_i[HW16-1:0]});
          endcase
        end else begin
          hit_o = 1'b0;
        end
      end
      CL_MISC1: begin
        case (fn_i)
          4'h0: res_o = bit_rev_bytes(src1_i);
          4'h1: res_o = byte_swap(src1_i);
          4'h2: res_o = {src2_i[HALF-1:0], src1_i[HALF-1:0]};
          default: hit_o = 1'b0;
        endcase
      end
      CL_FUSE: begin
        if (fn_i[3]) hit_o = 1'b0;
        else if (fn_i[0]) res_o = xword_t'(base[HW16-1:0]);
        else res_o = xword_t'(base[0]);
      end
      default: hit_o = 1'b0;
    endcase
    if (!hit_o) res_o = '0;
  end
endmodule

// File: rtl/fuse_alu_branch.sv
module fuse_alu_branch
  import fuse_alu_pkg::*;
(
  input  op_class_e      cls_i,
  input  logic [FNW-1:0] fn_i,
  input  xword_t         src1_i,
  input  xword_t         src2_i,
  output logic           taken_o
);
  logic cond;
  logic legal;

  always_comb begin
    case (fn_i[3:2])
      2'b00:   cond = (src1_i == src2_i);
      2'b10:   cond = ($signed(src1_i) < $signed(src2_i));
      2'b11:   cond = (src1_i < src2_i);
      default: cond = 1'b0;
    endcase
    legal   = (cls_i == CL_BRANCH) && !fn_i[0] && (fn_i[3:2] != 2'b01);
    taken_o = legal && (cond ^ fn_i[1]);
  end
endmodule

// File: rtl/fuse_alu.sv
module fuse_alu
  import fuse_alu_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic [XLEN-1:0] result_o,
  output logic            taken_o
);
  op_class_e      cls;
  logic [FNW-1:0] fn;
  xword_t sh_res, ar_res, lg_res;
  logic   sh_hit, ar_hit, lg_hit;

  assign cls = op_class_e'(op_i[OPW-1:FNW]);
  assign fn  = op_i[FNW-1:0];

  fuse_alu_shift u_shift (
    .cls_i(cls), .fn_i(fn), .src1_i(src1_i), .amt_i(src2_i[SHW-1:0]),
    .res_o(sh_res), .hit_o(sh_hit)
  );

  fuse_alu_arith #(.SR_BASE(29), .N_SHADD(4)) u_arith (
    .cls_i(cls), .fn_i(fn), .src1_i(src1_i), .src2_i(src2_i),
    .res_o(ar_res), .hit_o(ar_hit)
  );

  fuse_alu_logic u_logic (
    .cls_i(cls), .fn_i(fn), .src1_i(src1_i), .src2_i(src2_i),
    .res_o(lg_res), .hit_o(lg_hit)
  );

  fuse_alu_branch u_branch (
    .cls_i(cls), .fn_i(fn), .src1_i(src1_i), .src2_i(src2_i),
    .taken_o(taken_o)
  );

  always_comb begin
    case (cls)
      CL_SHIFT:                   result_o = sh_hit ? sh_res : '0;
      CL_WORD, CL_ADD, CL_SUB:    result_o = ar_hit ? ar_res : '0;
      CL_MISC0, CL_MISC1, CL_FUSE: result_o = lg_hit ? lg_res : '0;
      default:                    result_o = '0;
    endcase
  end

  always_comb begin
    // R13
    taken_class_chk: assert (!taken_o || cls == CL_BRANCH);
    // R13
    branch_result_zero_chk: assert (cls != CL_BRANCH || result_o == '0);
    // R5 R7 R9 R12: single-bit results leave the upper bits clear
    narrow_result_chk: assert (!(op_i == 7'b0110001 || op_i == 7'b0110010 ||
                                 op_i == 7'b0000110 || op_i == 7'b0010100 ||
                                 (cls == CL_FUSE && !op_i[0]))
                               || result_o[XLEN-1:1] == '0);
  end
endmodule

// File: tb/fuse_alu_test.sv
`timescale 1ns/1ps
module fuse_alu_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [6:0]  op;
  logic [63:0] src1, src2;
  logic [63:0] result;
  logic        taken;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  fuse_alu uut (.op_i(op), .src1_i(src1), .src2_i(src2), .result_o(result), .taken_o(taken));

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction
  function automatic logic [63:0] rotl64(input logic [63:0] a, input logic [5:0] s);
    logic [127:0] t = {a, a} << s;
    return t[127:64];
  endfunction
  function automatic logic [63:0] rotr64(input logic [63:0] a, input logic [5:0] s);
    logic [127:0] t = {a, a} >> s;
    return t[63:0];
  endfunction
  function automatic logic [31:0] rotl32(input logic [31:0] a, input logic [4:0] s);
    logic [63:0] t = {a, a} << s;
    return t[63:32];
  endfunction
  function automatic logic [31:0] rotr32(input logic [31:0] a, input logic [4:0] s);
    logic [63:0] t = {a, a} >> s;
    return t[31:0];
  endfunction
  function automatic logic [63:0] orc_ref(input logic [63:0] a);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (a[8*i +: 8] != 8'h00) r[8*i +: 8] = 8'hFF;
    return r;
  endfunction
  function automatic logic [63:0] brev_ref(input logic [63:0] a);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = a[(i & ~7) + (7 - (i & 7))];
    return r;
  endfunction
  function automatic logic [63:0] swap_ref(input logic [63:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = a[56 - 8*i +: 8];
    return r;
  endfunction

  // returns {known, taken, result}
  function automatic logic [65:0] ref_alu(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    logic kn = 1'b1;
    logic tk = 1'b0;
    logic [5:0] s = b[5:0];
    logic [4:0] ws = b[4:0];
    logic [31:0] lo = a[31:0];
    logic [63:0] sm = a + b;
    logic [63:0] uw = {32'h0, a[31:0]};
    case (o)
      7'b0000000: r = uw << s;
      7'b0000001: r = a << s;
      7'b0000010: begin r = a; r[s] = 1'b0; end
      7'b0000011: begin r = a; r[s] = 1'b1; end
      7'b0000100: begin r = a; r[s] = ~a[s]; end
      7'b0000101: r = a >> s;
      7'b0000110: r = {63'h0, a[s]};
      7'b0000111: r = 64'($signed(a) >>> s);
      7'b0001001: r = rotl64(a, s);
      7'b0001011: r = rotr64(a, s);
      7'b0010000: r = sx32(sm[31:0]);
      7'b0010001: r = sx32(lo[0] + b[31:0]);
      7'b0010010: r = sx32(lo - b[31:0]);
      7'b0010100: r = {63'h0, sm[0]};
      7'b0010101: r = {56'h0, sm[7:0]};
      7'b0010110: r = {48'h0, sm[15:0]};
      7'b0010111: r = {{48{sm[15]}}, sm[15:0]};
      7'b0011000: r = sx32(lo << ws);
      7'b0011001: r = sx32(lo >> ws);
      7'b0011010: r = sx32(32'($signed(lo) >>> ws));
      7'b0011100: r = sx32(rotl32(lo, ws));
      7'b0011101: r = sx32(rotr32(lo, ws));
      7'b0100000: r = uw + b;
      7'b0100001: r = sm;
      7'b0100010: r = b + {63'h0, a[0]};
      7'b0100100: r = (a >> 29) + b;
      7'b0100101: r = (a >> 30) + b;
      7'b0100110: r = (a >> 31) + b;
      7'b0100111: r = (a >> 32) + b;
      7'b0101000: r = uw * 2 + b;
      7'b0101001: r = a * 2 + b;
      7'b0101010: r = uw * 4 + b;
      7'b0101011: r = a * 4 + b;
      7'b0101100: r = uw * 8 + b;
      7'b0101101: r = a * 8 + b;
      7'b0101111: r = a * 16 + b;
      7'b0110000: r = a - b;
      7'b0110001: r = {63'h0, a < b};
      7'b0110010: r = {63'h0, $signed(a) < $signed(b)};
      7'b0110100: r = (a >= b) ? a : b;
      7'b0110101: r = (a <= b) ? a : b;
      7'b0110110: r = ($signed(a) >= $signed(b)) ? a : b;
      7'b0110111: r = ($signed(a) <= $signed(b)) ? a : b;
      7'b1000000: r = a & b;
      7'b1000001: r = a & ~b;
      7'b1000010: r = a | b;
      7'b1000011: r = a | ~b;
      7'b1000100: r = a ^ b;
      7'b1000101: r = ~(a ^ b);
      7'b1000110: r = orc_ref(a);
      7'b1001000: r = {{56{a[7]}}, a[7:0]};
      7'b1001001: r = {48'h0, b[7:0], a[7:0]};
      7'b1001010: r = {{48{a[15]}}, a[15:0]};
      7'b1001011: r = sx32({b[15:0], a[15:0]});
      7'b1010000: r = brev_ref(a);
      7'b1010001: r = swap_ref(a);
      7'b1010010: r = {b[31:0], a[31:0]};
      7'b1100000: r = {63'h0, a[0] & b[0]};
      7'b1100001: r = {48'h0, a[15:0] & b[15:0]};
      7'b1100010: r = {63'h0, a[0] | b[0]};
      7'b1100011: r = {48'h0, a[15:0] | b[15:0]};
      7'b1100100: r = {63'h0, a[0] ^ b[0]};
      7'b1100101: r = {48'h0, a[15:0] ^ b[15:0]};
      7'b1100110: r = {63'h0, a[7:0] != 8'h00};
      7'b1100111: r = {48'h0, orc_ref(a)[15:0]};
      7'b1110000: tk = (a == b);
      7'b1110010: tk = (a != b);
      7'b1111000: tk = ($signed(a) < $signed(b));
      7'b1111010: tk = ($signed(a) >= $signed(b));
      7'b1111100: tk = (a < b);
      7'b1111110: tk = (a >= b);
      default: kn = 1'b0;
    endcase
    return {kn, tk, r};
  endfunction

  function automatic string req_of(input logic [6:0] o, input logic kn);
    if (!kn) return "R1";
    case (o[6:4])
      3'b000: return (o[3:0] inside {4'h2, 4'h3, 4'h4, 4'h6}) ? "R7" : "R6";
      3'b001: return (o[3:0] inside {4'h4, 4'h5, 4'h6, 4'h7}) ? "R9" : "R8";
      3'b010: return o[3] ? "R3" : (o[2] ? "R4" : "R2");
      3'b011: return (o[3:0] == 4'h0) ? "R2" : "R5";
      3'b100: return o[3] ? "R11" : "R10";
      3'b101: return "R11";
      3'b110: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [65:0] e = ref_alu(op, src1, src2);
    n_tests++;
    if (result !== e[63:0] || taken !== e[64]) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h : got res=%h tk=%b, expected res=%h tk=%b",
               tag, op, src1, src2, result, taken, e[63:0], e[64]);
    end
  endtask

  task automatic apply(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    op = o; src1 = a; src2 = b;
    @(negedge clk);
    check_now(req_of(o, ref_alu(o, a, b)[65]));
  endtask

  logic [63:0] corner [12];

  initial begin
    corner[0]  = 64'h0;
    corner[1]  = 64'h1;
    corner[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
    corner[3]  = 64'h8000_0000_0000_0000;
    corner[4]  = 64'h7FFF_FFFF_FFFF_FFFF;
    corner[5]  = 64'h0000_0000_8000_0000;
    corner[6]  = 64'h0123_4567_89AB_CDEF;
    corner[7]  = 64'hFEDC_BA98_7654_3210;
    corner[8]  = 64'd63;
    corner[9]  = 64'd32;
    corner[10] = 64'h45;
    corner[11] = 64'h0000_0000_FFFF_FFFF;
    op = '0; src1 = '0; src2 = '0;
    @(negedge clk);
    // R6 idle state with all-zero inputs: result 0, flag 0
    n_tests++;
    if (result !== 64'h0 || taken !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 idle: got res=%h tk=%b, expected res=0 tk=0", result, taken);
    end
    // R1 an unused code gives zero
    apply(7'b1111111, 64'hDEAD_BEEF_0000_0001, 64'h5);
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int o = 0; o < 128; o++) apply(7'(o), corner[i], corner[j]);
    begin
      logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
      for (int p = 0; p < 64; p++) begin
        logic [63:0] ra, rb;
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17); ra = x;
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17); rb = x;
        if (p % 4 == 0) rb = ra;
        for (int o = 0; o < 128; o++) apply(7'(o), ra, rb);
      end
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog expired: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule